// File: doc/BRIEF.md
# Dual Saturating Accumulator Adder

This block holds two signed accumulators and one shared adder/subtracter. Each valid operation takes an operand that is already scaled and sign-extended to the accumulator width. It adds the operand to the selected accumulator or subtracts it. The accumulator side of the adder can be forced to zero, which loads the operand or its negation. The result then passes through one of three overflow policies before it is written back. The policy comes from that accumulator's saturation enable and a shared range select. With saturation on and the full range selected, the result clamps at the full-width extremes. With saturation on and the narrow range selected, it clamps at the 1.31 extremes and the guard bits are ignored. With saturation off, the wrapped result is kept and only a flag records the catastrophic overflow.

Each accumulator has two flags. The guard flag describes the most recent write to that accumulator. The saturation flag is sticky until it is cleared. Two summary outputs OR the flags of both accumulators, and per-accumulator trap requests combine the flags with enable inputs. The default width is 40 bits, of which 8 are guard bits above a 32-bit body.

Top module: `acc_sat_adder`

## Requirements
- R1: After reset both accumulators, both guard flags, both saturation flags, the two summary outputs and both trap requests are zero.
- R2: When op_valid is 1, the accumulator named by acc_sel (0 = first, 1 = second) is written on the next rising clock edge. It receives X + op_data when op_sub is 0, or X - op_data when op_sub is 1. X is the accumulator's old value, or zero when zero_acc is 1. The other accumulator, and both accumulators when op_valid is 0, keep their values.
- R3: Each operation rewrites the target's guard flag, and only the target's. Under the full-range and wrap policies the flag is 1 exactly when bits 39 down to 32 of the written value are not all equal.
- R4: With sat_en[target]=1 and sat_mode_32=0, a true result above 2^39-1 writes 0x7FFFFFFFFF, and one below -2^39 writes 0x8000000000. Either case sets the target's saturation flag.
- R5: With sat_en[target]=1 and sat_mode_32=1, a true result above 2^31-1 writes 0x007FFFFFFF, and one below -2^31 writes 0xFF80000000. Either case sets the saturation flag. Under this policy the target's guard flag is always written 0.
- R6: With sat_en[target]=0, the result wraps modulo 2^40. The saturation flag is set when the true result lies outside [-2^39, 2^39-1].
- R7: A saturation flag stays 1 until clr_sat[i] is 1 at a clock edge. A set caused by an operation at the same edge wins over the clear.
- R8: ovf_any is the OR of both guard flags, and sat_any is the OR of both saturation flags.
- R9: trap_req[i] is 1 when ovf_flag[i] and ovf_trap_en[i] are both 1. It is also 1 when sat_flag[i] is 1, sat_en[i] is 0 and cat_trap_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Perform an operation this cycle |
| op_data | input | ACC_W | Sign-extended operand |
| acc_sel | input | 1 | Target accumulator: 0 first, 1 second |
| op_sub | input | 1 | 1 subtract, 0 add |
| zero_acc | input | 1 | Force the accumulator side of the adder to zero |
| sat_en | input | 2 | Per-accumulator saturation enable |
| sat_mode_32 | input | 1 | 1 narrow (1.31) range, 0 full range |
| clr_sat | input | 2 | Per-accumulator saturation flag clear |
| ovf_trap_en | input | 2 | Per-accumulator guard-overflow trap enable |
| cat_trap_en | input | 1 | Catastrophic-overflow trap enable |
| acc_a | output | ACC_W | First accumulator |
| acc_b | output | ACC_W | Second accumulator |
| ovf_flag | output | 2 | Guard-overflow flags |
| sat_flag | output | 2 | Sticky saturation flags |
| ovf_any | output | 1 | OR of the guard flags |
| sat_any | output | 1 | OR of the saturation flags |
| trap_req | output | 2 | Per-accumulator trap requests |

## Verification
The assertions assume that acc_sel, sat_en and sat_mode_32 are stable and known in every cycle in which op_valid is 1. They also assume that a clear strobe is not meant to undo a saturation that happens at the same edge. The stimulus changes every input only at the falling edge. It draws operands from a mix of small values, values near the 32-bit and 40-bit limits, and fully random words, so that all three policies meet both overflow directions. Clear strobes are random and sometimes coincide with a saturating operation.

// File: rtl/acc_pkg.sv
package acc_pkg;

   typedef enum logic [1:0] {
      POL_WRAP   = 2'd0,
      POL_WIDE   = 2'd1,
      POL_NARROW = 2'd2
   } sat_pol_e;

   function automatic sat_pol_e pick_pol(input logic sat_on, input logic narrow);
      if (!sat_on)     return POL_WRAP;
      else if (narrow) return POL_NARROW;
      else             return POL_WIDE;
   endfunction

endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
   parameter int W         = 40,
   parameter int OVF_STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         zero_a,
   output logic [W-1:0] sum,
   output logic         ov_top,
   output logic         true_neg
);
   logic [W-1:0] a_eff;
   logic [W-1:0] b_eff;

   assign a_eff = zero_a ? '0 : a;
   assign b_eff = sub ? ~b : b;

   generate
      if (OVF_STYLE == 0) begin : g_sign_cmp
         assign sum    = a_eff + b_eff + W'(sub);
         assign ov_top = (a_eff[W-1] == b_eff[W-1]) && (sum[W-1] != a_eff[W-1]);
      end else begin : g_carry_xor
         logic         cout;
         logic         cin_msb;
         assign {cout, sum} = {1'b0, a_eff} + {1'b0, b_eff} + (W+1)'(sub);
         assign cin_msb     = sum[W-1] ^ a_eff[W-1] ^ b_eff[W-1];
         assign ov_top      = cin_msb ^ cout;
      end
   endgenerate

   // On overflow the real sign is the common sign of the two inputs.
   assign true_neg = ov_top ? a_eff[W-1] : sum[W-1];

endmodule

// File: rtl/acc_clamp.sv
module acc_clamp
   import acc_pkg::*;
#(
   parameter int W       = 40,
   parameter int GUARD_W = 8
) (
   input  logic [W-1:0] sum,
   input  logic         ov_top,
   input  logic         true_neg,
   input  sat_pol_e     pol,
   output logic [W-1:0] res,
   output logic         sat_hit,
   output logic         guard_ovf
);
   localparam int LOW_W = W - GUARD_W;

   localparam logic [W-1:0] WIDE_POS   = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] WIDE_NEG   = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] NARROW_POS = {{(GUARD_W+1){1'b0}}, {(LOW_W-1){1'b1}}};
   localparam logic [W-1:0] NARROW_NEG = {{(GUARD_W+1){1'b1}}, {(LOW_W-1){1'b0}}};

   logic [GUARD_W:0]   upper;
   logic               narrow_ov;
   logic [GUARD_W-1:0] res_guard;

   assign upper     = sum[W-1:LOW_W-1];
   assign narrow_ov = ov_top || !((&upper) || !(|upper));

   always_comb begin
      res     = sum;
      sat_hit = 1'b0;
      unique case (pol)
         POL_WIDE: begin
            if (ov_top) begin
               res     = true_neg ? WIDE_NEG : WIDE_POS;
               sat_hit = 1'b1;
            end
         end
         POL_NARROW: begin
            if (narrow_ov) begin
               res     = true_neg ? NARROW_NEG : NARROW_POS;
               sat_hit = 1'b1;
            end
         end
         default: begin
            sat_hit = ov_top;
         end
      endcase
   end

   assign res_guard = res[W-1:LOW_W];
   assign guard_ovf = (pol != POL_NARROW) && !((&res_guard) || !(|res_guard));

endmodule

// File: rtl/acc_slice.sv
module acc_slice #(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic [W-1:0] res,
   input  logic         sat_hit,
   input  logic         guard_ovf,
   input  logic         clr,
   output logic [W-1:0] acc_q,
   output logic         ovf_q,
   output logic         sat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
         sat_q <= 1'b0;
      end else begin
         if (upd) begin
            acc_q <= res;
            ovf_q <= guard_ovf;
         end
         if (upd && sat_hit) sat_q <= 1'b1;
         else if (clr)       sat_q <= 1'b0;
      end
   end

   // R2: an idle slice keeps value and guard flag
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(acc_q) && $stable(ovf_q)));

   // R7: saturation flag persists without a clear
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_q && !clr) |=> sat_q);

   // R7: clear wins unless the same edge saturates
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(upd && sat_hit)) |=> !sat_q);

endmodule

// File: rtl/acc_sat_adder.sv
module acc_sat_adder
   import acc_pkg::*;
#(
   parameter int ACC_W     = 40,
   parameter int GUARD_W   = 8,
   parameter int OVF_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [ACC_W-1:0] op_data,
   input  logic             acc_sel,
   input  logic             op_sub,
   input  logic             zero_acc,
   input  logic [1:0]       sat_en,
   input  logic             sat_mode_32,
   input  logic [1:0]       clr_sat,
   input  logic [1:0]       ovf_trap_en,
   input  logic             cat_trap_en,
   output logic [ACC_W-1:0] acc_a,
   output logic [ACC_W-1:0] acc_b,
   output logic [1:0]       ovf_flag,
   output logic [1:0]       sat_flag,
   output logic             ovf_any,
   output logic             sat_any,
   output logic [1:0]       trap_req
);
   localparam int NUM_ACC = 2;
   localparam int LOW_W   = ACC_W - GUARD_W;

   generate
      if (GUARD_W < 1 || LOW_W < 2) begin : g_bad_split
         $error("acc_sat_adder: GUARD_W must leave at least two body bits");
      end
      if (OVF_STYLE != 0 && OVF_STYLE != 1) begin : g_bad_style
         $error("acc_sat_adder: OVF_STYLE must be 0 or 1");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q [NUM_ACC];
   logic [NUM_ACC-1:0] ovf_q;
   logic [NUM_ACC-1:0] sat_q;

   logic [ACC_W-1:0] x_sel;
   sat_pol_e         pol;
   logic [ACC_W-1:0] sum;
   logic             ov_top;
   logic             true_neg;
   logic [ACC_W-1:0] res;
   logic             sat_hit;
   logic             guard_ovf;

   assign x_sel = acc_sel ? acc_q[1] : acc_q[0];
   assign pol   = pick_pol(sat_en[acc_sel], sat_mode_32);

   acc_addsub #(.W(ACC_W), .OVF_STYLE(OVF_STYLE)) u_addsub (
      .a        (x_sel),
      .b        (op_data),
      .sub      (op_sub),
      .zero_a   (zero_acc),
      .sum      (sum),
      .ov_top   (ov_top),
      .true_neg (true_neg)
   );

   acc_clamp #(.W(ACC_W), .GUARD_W(GUARD_W)) u_clamp (
      .sum       (sum),
      .ov_top    (ov_top),
      .true_neg  (true_neg),
      .pol       (pol),
      .res       (res),
      .sat_hit   (sat_hit),
      .guard_ovf (guard_ovf)
   );

   generate
      for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
         localparam logic SEL = 1'(g);
         logic upd;
         assign upd = op_valid && (acc_sel == SEL);

         acc_slice #(.W(ACC_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd       (upd),
            .res       (res),
            .sat_hit   (sat_hit),
            .guard_ovf (guard_ovf),
            .clr       (clr_sat[g]),
            .acc_q     (acc_q[g]),
            .ovf_q     (ovf_q[g]),
            .sat_q     (sat_q[g])
         );

         assign trap_req[g] = (ovf_q[g] && ovf_trap_en[g]) ||
                              (sat_q[g] && !sat_en[g] && cat_trap_en);

         // R5: narrow policy leaves the guard flag clear and the value in 1.31 range
         a_r5_narrow_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && acc_sel == SEL && sat_en[g] && sat_mode_32) |=>
            (!ovf_q[g] && ((&acc_q[g][ACC_W-1:LOW_W-1]) || !(|acc_q[g][ACC_W-1:LOW_W-1]))));
      end
   endgenerate

   // R2: the accumulator not selected is untouched
   a_r2_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !acc_sel) |=> $stable(acc_q[1]));

   assign acc_a    = acc_q[0];
   assign acc_b    = acc_q[1];
   assign ovf_flag = ovf_q;
   assign sat_flag = sat_q;
   assign ovf_any  = |ovf_q;
   assign sat_any  = |sat_q;

endmodule

// File: tb/tb_acc_sat_adder.sv
module tb_acc_sat_adder;
   localparam int W = 40;
   localparam longint MAX40 = (longint'(1) <<< 39) - 1;
   localparam longint MIN40 = -(longint'(1) <<< 39);
   localparam longint MAX32 = (longint'(1) <<< 31) - 1;
   localparam longint MIN32 = -(longint'(1) <<< 31);

   logic clk = 0;
   logic rst_n = 0;
   logic op_valid = 0;
   logic [W-1:0] op_data = '0;
   logic acc_sel = 0, op_sub = 0, zero_acc = 0, sat_mode_32 = 0, cat_trap_en = 0;
   logic [1:0] sat_en = '0, clr_sat = '0, ovf_trap_en = '0;
   logic [W-1:0] acc_a, acc_b;
   logic [1:0] ovf_flag, sat_flag, trap_req;
   logic ovf_any, sat_any;

   always #2 clk = ~clk;

   acc_sat_adder dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_data(op_data),
      .acc_sel(acc_sel), .op_sub(op_sub), .zero_acc(zero_acc), .sat_en(sat_en),
      .sat_mode_32(sat_mode_32), .clr_sat(clr_sat), .ovf_trap_en(ovf_trap_en),
      .cat_trap_en(cat_trap_en), .acc_a(acc_a), .acc_b(acc_b), .ovf_flag(ovf_flag),
      .sat_flag(sat_flag), .ovf_any(ovf_any), .sat_any(sat_any), .trap_req(trap_req)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [W-1:0] m_acc [2];
   logic [1:0]   m_ovf, m_sat;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic compare(string req);
      logic [1:0] trap_e;
      for (int i = 0; i < 2; i++)
         trap_e[i] = (m_ovf[i] & ovf_trap_en[i]) | (m_sat[i] & ~sat_en[i] & cat_trap_en);
      chk(req, "acc_a", 64'(acc_a), 64'(m_acc[0]));
      chk(req, "acc_b", 64'(acc_b), 64'(m_acc[1]));
      chk(req, "ovf_flag", 64'(ovf_flag), 64'(m_ovf));
      chk(req, "sat_flag", 64'(sat_flag), 64'(m_sat));
      chk("R8", "ovf_any", 64'(ovf_any), 64'(|m_ovf));
      chk("R8", "sat_any", 64'(sat_any), 64'(|m_sat));
      chk("R9", "trap_req", 64'(trap_req), 64'(trap_e));
   endtask

   // Reference model of one clock edge
   task automatic model_edge(logic v, logic sel, logic sub, logic zero, logic [W-1:0] op,
                             logic [1:0] sen, logic narrow, logic [1:0] clr);
      longint x, o, exact;
      logic [W-1:0] raw, res, xv;
      logic hit, g;
      hit = 0; g = 0; res = '0;
      if (v) begin
         xv    = zero ? '0 : m_acc[sel];
         x     = longint'(signed'(xv));
         o     = longint'(signed'(op));
         exact = sub ? x - o : x + o;
         raw   = exact[W-1:0];
         res   = raw;
         if (sen[sel] && !narrow) begin
            if (exact > MAX40) begin res = 40'h7F_FFFF_FFFF; hit = 1; end
            if (exact < MIN40) begin res = 40'h80_0000_0000; hit = 1; end
         end else if (sen[sel]) begin
            if (exact > MAX32) begin res = 40'h00_7FFF_FFFF; hit = 1; end
            if (exact < MIN32) begin res = 40'hFF_8000_0000; hit = 1; end
         end else begin
            hit = (exact > MAX40) || (exact < MIN40);
         end
         g = !(sen[sel] && narrow) && !(res[39:32] == 8'h00 || res[39:32] == 8'hFF);
      end
      for (int i = 0; i < 2; i++)
         if (clr[i]) m_sat[i] = 1'b0;
      if (v) begin
         m_acc[sel] = res;
         m_ovf[sel] = g;
         if (hit) m_sat[sel] = 1'b1;
      end
   endtask

   task automatic step(string req, logic v, logic sel, logic sub, logic zero,
                       logic [W-1:0] op, logic [1:0] sen, logic narrow, logic [1:0] clr);
      op_valid = v; acc_sel = sel; op_sub = sub; zero_acc = zero; op_data = op;
      sat_en = sen; sat_mode_32 = narrow; clr_sat = clr;
      @(posedge clk);
      model_edge(v, sel, sub, zero, op, sen, narrow, clr);
      @(negedge clk);
      op_valid = 0; clr_sat = '0;
      compare(req);
   endtask

   function automatic logic [W-1:0] pick_operand();
      logic [W-1:0] r;
      r = {$urandom(), $urandom()} >> 24;
      case ($urandom_range(0, 5))
         0: return W'($urandom_range(0, 40)) ^ {W{r[0]}};
         1: return 40'h00_7FFF_FFF0 + W'($urandom_range(0, 31));
         2: return 40'hFF_8000_0010 - W'($urandom_range(0, 31));
         3: return 40'h7F_FFFF_FFF0 + W'($urandom_range(0, 15));
         4: return 40'h80_0000_0000 + W'($urandom_range(0, 15));
         default: return r;
      endcase
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      m_acc[0] = '0; m_acc[1] = '0; m_ovf = '0; m_sat = '0;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1;
      @(negedge clk);
      compare("R1");

      // R2: load, add, subtract, other accumulator untouched
      step("R2", 1, 0, 0, 1, 40'd5, 2'b00, 0, 2'b00);
      step("R2", 1, 0, 0, 0, 40'd3, 2'b00, 0, 2'b00);
      step("R2", 1, 0, 1, 0, 40'd10, 2'b00, 0, 2'b00);
      step("R2", 1, 1, 1, 1, 40'h100, 2'b00, 0, 2'b00);
      step("R2", 0, 0, 0, 0, 40'h123, 2'b00, 0, 2'b00);

      // R3: guard flag follows every write of the target
      step("R3", 1, 0, 0, 0, 40'h01_0000_0000, 2'b01, 0, 2'b00);
      step("R3", 1, 1, 0, 0, 40'd1, 2'b00, 0, 2'b00);
      step("R3", 1, 0, 1, 0, 40'h01_0000_0000, 2'b01, 0, 2'b00);

      // R4: full-range clamps, both directions
      step("R4", 1, 0, 0, 1, 40'h7F_FFFF_FFFF, 2'b00, 0, 2'b00);
      step("R4", 1, 0, 0, 0, 40'd1, 2'b11, 0, 2'b00);
      step("R4", 1, 1, 0, 1, 40'h80_0000_0000, 2'b00, 0, 2'b00);
      step("R4", 1, 1, 1, 0, 40'd1, 2'b11, 0, 2'b00);

      // R7: clear, then clear coinciding with a new saturation
      step("R7", 0, 0, 0, 0, 40'd0, 2'b11, 0, 2'b01);
      step("R7", 1, 1, 1, 0, 40'd1, 2'b11, 0, 2'b10);
      step("R7", 0, 0, 0, 0, 40'd0, 2'b11, 0, 2'b10);

      // R5: narrow clamps and suppressed guard flag
      step("R5", 1, 0, 0, 1, 40'h00_7FFF_FFFF, 2'b00, 0, 2'b00);
      step("R5", 1, 0, 0, 0, 40'd1, 2'b01, 1, 2'b00);
      step("R5", 1, 1, 1, 1, 40'h00_8000_0000, 2'b00, 0, 2'b00);
      step("R5", 1, 1, 1, 0, 40'd1, 2'b10, 1, 2'b00);
      step("R5", 1, 0, 0, 0, 40'h10_0000_0000, 2'b01, 1, 2'b11);

      // R6 and R9: wrap with catastrophic flag and traps
      ovf_trap_en = 2'b01; cat_trap_en = 1;
      step("R6", 1, 0, 0, 1, 40'h7F_FFFF_FFFF, 2'b00, 0, 2'b11);
      step("R6", 1, 0, 0, 0, 40'd1, 2'b00, 0, 2'b00);
      step("R9", 1, 1, 1, 1, 40'h80_0000_0000, 2'b00, 0, 2'b00);
      step("R9", 0, 0, 0, 0, 40'd0, 2'b11, 0, 2'b00);

      // Random mix across all policies
      for (int n = 0; n < 4000; n++) begin
         ovf_trap_en = 2'($urandom());
         cat_trap_en = 1'($urandom());
         step("R2", 1'($urandom_range(0, 7) != 0), 1'($urandom()), 1'($urandom()),
              1'($urandom_range(0, 5) == 0), pick_operand(), 2'($urandom()),
              1'($urandom()), ($urandom_range(0, 7) == 0) ? 2'($urandom()) : 2'b00);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule